// File: doc/BRIEF.md
# Audio Receive DMA Channel with Automatic Restart

This block is the receive half of an audio DMA channel. Samples from a codec serial interface go into a small internal FIFO. The channel then writes them to a memory buffer one 32-bit word at a time. The write address starts at a programmed start address and steps by 4 bytes for each word. The channel stops once it has moved the programmed number of bytes. It then raises a sticky transfer-end interrupt.

Software programs the start address and byte count. It then sets the activate bit. If the restart bit is set, the channel reloads its address pointer and remaining count from the preserved registers at the end of every pass, and loops over the buffer until software stops it. A stop request moves the channel into a drain phase. In that phase it takes no new samples, and it writes the words still held in the FIFO while bytes remain. The stop bit reads back as 1 until the drain has finished. After a stop, the remaining-count register shows how many bytes were not moved.

Top module: `audio_rx_dma`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0, `memReq` is 0 and `sampleReady` is 0.
- R2: Register offsets are 0 = start address, 1 = byte count, 2 = remaining bytes (read only), 3 = control. In the control register, bit 0 is written as activate and reads as running, bit 1 is restart, bit 2 is written 1 to stop and reads as draining, and bit 3 is the interrupt flag. Writing bit 0 = 1 while idle loads the remaining count from the byte count, with the low two bits forced to 0, and sets running.
- R3: Word k of a pass is written to start address + 4·k. Words carry the FIFO samples in arrival order, and each word lowers the remaining count by 4.
- R4: A pass ends by itself once the byte count has been moved. At that point running clears, the remaining count reads 0, the interrupt flag sets, and the start and count registers keep their values.
- R5: Writing activate again after completion repeats the same buffer, with no need to reprogram the start or count registers.
- R6: Writing activate while running has no effect on the count or the address.
- R7: With restart set, every pass end sets the interrupt flag and reloads the address and count, so the writes wrap back to the start address. The channel keeps running until it is stopped.
- R8: Writing 1 to control bit 2 while running stops sample intake (`sampleReady` = 0). The FIFO contents are then written to memory while bytes remain. Bit 2 reads 1 until this drain finishes, then reads 0, and the interrupt flag sets.
- R9: After a stop, the remaining register holds the number of bytes that were not transferred.
- R10: During a drain, writes to the start, count or activate bits never make the channel run.
- R11: The interrupt flag drives `irq`. It stays set until a control write with bit 3 = 1.
- R12: Activating with a byte count below 4 sets the interrupt flag at once and performs no memory write.
- R13: `memReq` with its `memAddr` and `memData` stays asserted and unchanged until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| sampleValid | input | 1 | Codec sample available |
| sampleData | input | 32 | Codec sample word |
| sampleReady | output | 1 | Channel accepts the sample this cycle |
| memReq | output | 1 | Memory write request |
| memAddr | output | 32 | Memory write address |
| memData | output | 32 | Memory write data |
| memAck | input | 1 | Memory accepted the write |
| irq | output | 1 | Transfer-end interrupt (sticky) |

## Verification
A single 16-byte pass, with a steady sample stream and an immediately acknowledging memory, shows that addresses, data order and the self-stop are correct. Repeating the pass without reprogramming, and issuing a second activate partway through a 32-byte pass, separates a real restart from a spurious one: the spurious restart would add words. A restart run over an 8-byte buffer is watched for three passes, which shows the address wrapping back and the channel continuing. A stop is issued while the memory withholds its acknowledge with a full FIFO. This shows that the stop bit stays high through the drain, that writes made meanwhile do not restart the channel, and that the residual count is exact. A zero byte count checks the empty-pass corner.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } chanState_t;

  // strobes from control to datapath/fifo
  typedef struct packed {
    logic load;    // pointer <= start, remaining <= count
    logic step;    // one word written: pointer += 4, remaining -= 4, fifo pop
    logic setIrq;  // raise transfer-end flag
    logic flush;   // discard fifo contents
  } dmaStrobe_t;

  localparam logic [1:0] REG_START  = 2'd0;
  localparam logic [1:0] REG_COUNT  = 2'd1;
  localparam logic [1:0] REG_REMAIN = 2'd2;
  localparam logic [1:0] REG_CTRL   = 2'd3;

  localparam int CTL_ACT  = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_STOP = 2;
  localparam int CTL_IRQ  = 3;

endpackage

// File: rtl/audio_dma_fifo.sv
module audio_dma_fifo
  import audio_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acceptEn,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sampleReady,
  input  dmaStrobe_t        strobe,
  output logic [DATA_W-1:0] headData,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic              full, push, pop;

  assign full        = (fill == CNT_W'(DEPTH));
  assign empty       = (fill == '0);
  assign sampleReady = acceptEn && !full;
  assign push        = sampleValid && sampleReady;
  assign pop         = strobe.step;
  assign headData    = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !strobe.flush) store[wrPtr] <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));
  p_no_pop_empty_r13: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/audio_dma_ctrl.sv
module audio_dma_ctrl
  import audio_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actCmd,
  input  logic       stopCmd,
  input  logic       fifoEmpty,
  input  logic       memAck,
  input  logic       lastWord,
  input  logic       remZero,
  input  logic       countZero,
  input  logic       autoReload,
  output dmaStrobe_t strobe,
  output logic       memReq,
  output logic       acceptEn,
  output logic       running,
  output logic       draining
);
  chanState_t state, nextState;
  logic xfer;

  assign memReq   = (state != ST_IDLE) && !fifoEmpty && !remZero;
  assign xfer     = memReq && memAck;
  assign running  = (state == ST_RUN);
  assign draining = (state == ST_DRAIN);
  assign acceptEn = running;

  always_comb begin
    nextState   = state;
    strobe      = '0;
    strobe.step = xfer;
    case (state)
      ST_IDLE: begin
        if (actCmd) begin
          if (countZero) begin
            strobe.setIrq = 1'b1;
          end else begin
            strobe.load  = 1'b1;
            strobe.flush = 1'b1;
            nextState    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (stopCmd) begin
          nextState = ST_DRAIN;
        end else if (xfer && lastWord) begin
          strobe.setIrq = 1'b1;
          if (autoReload) strobe.load = 1'b1;
          else            nextState   = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (!memReq) begin
          strobe.flush  = 1'b1;
          strobe.setIrq = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  p_drain_no_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DRAIN |=> state != ST_RUN);

endmodule

// File: rtl/audio_dma_dp.sv
module audio_dma_dp
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  dmaStrobe_t        strobe,
  input  logic              running,
  input  logic              draining,
  output logic              actCmd,
  output logic              stopCmd,
  output logic              lastWord,
  output logic              remZero,
  output logic              countZero,
  output logic              autoReload,
  output logic              irqFlag,
  output logic [ADDR_W-1:0] memAddr
);
  localparam int ALIGN = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ~ADDR_W'(BYTES - 1);
  localparam logic [CNT_W-1:0]  CNT_MASK  = ~CNT_W'(BYTES - 1);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(BYTES);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BYTES);

  logic [ADDR_W-1:0] startAddr, ptr;
  logic [CNT_W-1:0]  byteCount, remaining;
  logic ctrlWr, clrIrq;

  assign ctrlWr    = regWr && (regAddr == REG_CTRL);
  assign actCmd    = ctrlWr && regWdata[CTL_ACT];
  assign stopCmd   = ctrlWr && regWdata[CTL_STOP];
  assign clrIrq    = ctrlWr && regWdata[CTL_IRQ];
  assign lastWord  = (remaining == CNT_STEP);
  assign remZero   = (remaining == '0);
  assign countZero = (byteCount == '0);
  assign memAddr   = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr  <= '0;
      byteCount  <= '0;
      autoReload <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        REG_START: startAddr  <= regWdata[ADDR_W-1:0] & ADDR_MASK;
        REG_COUNT: byteCount  <= regWdata[CNT_W-1:0] & CNT_MASK;
        REG_CTRL:  autoReload <= regWdata[CTL_AUTO];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      remaining <= '0;
    end else if (strobe.load) begin
      ptr       <= startAddr;
      remaining <= byteCount;
    end else if (strobe.step) begin
      ptr       <= ptr + ADDR_STEP;
      remaining <= remaining - CNT_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              irqFlag <= 1'b0;
    else if (strobe.setIrq) irqFlag <= 1'b1;
    else if (clrIrq)        irqFlag <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_START:  regRdata = REG_W'(startAddr);
      REG_COUNT:  regRdata = REG_W'(byteCount);
      REG_REMAIN: regRdata = REG_W'(remaining);
      default: begin
        regRdata[CTL_ACT]  = running;
        regRdata[CTL_AUTO] = autoReload;
        regRdata[CTL_STOP] = draining;
        regRdata[CTL_IRQ]  = irqFlag;
      end
    endcase
  end

  p_step_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !strobe.load |=> remaining == $past(remaining) - CNT_STEP);
  p_reload_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ptr == $past(startAddr) && remaining == $past(byteCount));
  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !clrIrq |=> irqFlag);

  if (ALIGN < 1) begin : g_bad_align
    initial $error("BYTES must be at least 2");
  end

endmodule

// File: rtl/audio_rx_dma.sv
module audio_rx_dma
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int REG_W      = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              sampleReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memAck,
  output logic              irq
);
  localparam int BYTES = DATA_W / 8;

  dmaStrobe_t strobe;
  logic actCmd, stopCmd, lastWord, remZero, countZero, autoReload;
  logic running, draining, acceptEn, fifoEmpty;

  audio_dma_ctrl u_ctrl (
    .clk, .rstN, .actCmd, .stopCmd, .fifoEmpty, .memAck, .lastWord,
    .remZero, .countZero, .autoReload, .strobe, .memReq, .acceptEn,
    .running, .draining
  );

  audio_dma_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W), .BYTES(BYTES)) u_dp (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata, .strobe, .running,
    .draining, .actCmd, .stopCmd, .lastWord, .remZero, .countZero,
    .autoReload, .irqFlag(irq), .memAddr
  );

  audio_dma_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rstN, .acceptEn, .sampleValid, .sampleData, .sampleReady,
    .strobe, .headData(memData), .empty(fifoEmpty)
  );

  p_drain_end_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(draining) |-> irq);
  p_req_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memData));

endmodule

// File: tb/audio_rx_dma_bench.sv
module audio_rx_dma_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sampleValid = 1'b0;
  logic [31:0] sampleData = '0;
  logic        sampleReady;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memAck = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic srcOn = 1'b0;
  logic ackOn = 1'b0;
  logic [31:0] seq = 32'h100;
  logic [31:0] logAddr [512];
  logic [31:0] logData [512];
  int logCnt = 0;

  always #2 clk = ~clk;

  audio_rx_dma u_audio_rx_dma (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata, .sampleValid,
    .sampleData, .sampleReady, .memReq, .memAddr, .memData, .memAck, .irq
  );

  always @(negedge clk) begin
    sampleValid <= srcOn;
    sampleData  <= seq;
    memAck      <= ackOn && memReq && !memAck;
  end

  always @(posedge clk) begin
    if (sampleValid && sampleReady) seq <= seq + 1;
    if (memReq && memAck && logCnt < 512) begin
      logAddr[logCnt] <= memAddr;
      logData[logCnt] <= memData;
      logCnt <= logCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIrq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  task automatic waitWords(input int target, input int limit);
    for (int i = 0; i < limit && logCnt < target; i++) @(negedge clk);
  endtask

  task automatic checkPass(input int base, input int n, input logic [31:0] start, input string tag);
    for (int k = 0; k < n; k++) begin
      check(logAddr[base+k] == start + 32'(4*k), tag, logAddr[base+k], start + 32'(4*k));
      if (k > 0)
        check(logData[base+k] == logData[base+k-1] + 1, tag, logData[base+k], logData[base+k-1] + 1);
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    check(!irq && !memReq && !sampleReady, "R1 outputs reset", {irq, memReq, sampleReady}, 0);
  endtask

  task automatic testNormal();
    logic [31:0] v;
    int base;
    regWrite(2'd0, 32'h1000);
    regWrite(2'd1, 32'd18);            // R2: low bits dropped -> 16
    srcOn = 1'b1; ackOn = 1'b1;
    base = logCnt;
    regWrite(2'd3, 32'h1);
    regRead(2'd2, v);
    check(v == 16, "R2 remaining loaded", v, 16);
    regRead(2'd3, v);
    check(v[0] == 1'b1, "R2 running set", v, 1);
    waitIrq(200);
    srcOn = 1'b0;
    check(logCnt - base == 4, "R4 word count", logCnt - base, 4);
    checkPass(base, 4, 32'h1000, "R3 address/data order");
    regRead(2'd2, v);
    check(v == 0, "R4 remaining zero", v, 0);
    regRead(2'd3, v);
    check(v[0] == 0 && v[3] == 1, "R4 stopped with irq", v, 32'h8);
    regRead(2'd0, v);
    check(v == 32'h1000, "R4 start kept", v, 32'h1000);
    regRead(2'd1, v);
    check(v == 16, "R4 count kept", v, 16);
    regWrite(2'd3, 32'h8);
    check(irq == 1'b0, "R11 irq cleared by write 1", irq, 0);
  endtask

  task automatic testRestart();
    int base;
    srcOn = 1'b1;
    base = logCnt;
    regWrite(2'd3, 32'h1);
    waitIrq(200);
    srcOn = 1'b0;
    check(logCnt - base == 4, "R5 repeat word count", logCnt - base, 4);
    checkPass(base, 4, 32'h1000, "R5 repeat same buffer");
    regWrite(2'd3, 32'h8);
  endtask

  task automatic testActWhileRunning();
    int base;
    regWrite(2'd1, 32'd32);
    srcOn = 1'b1;
    base = logCnt;
    regWrite(2'd3, 32'h1);
    waitWords(base + 2, 200);
    regWrite(2'd3, 32'h1);
    check(irq == 1'b0, "R11 irq held low mid-pass", irq, 0);
    waitIrq(300);
    repeat (10) @(negedge clk);
    srcOn = 1'b0;
    check(logCnt - base == 8, "R6 second activate ignored", logCnt - base, 8);
    checkPass(base, 8, 32'h1000, "R6 addresses unchanged");
    regWrite(2'd3, 32'h8);
  endtask

  task automatic testAutoReload();
    logic [31:0] v;
    int base;
    regWrite(2'd0, 32'h2000);
    regWrite(2'd1, 32'd8);
    srcOn = 1'b1;
    base = logCnt;
    regWrite(2'd3, 32'h3);
    waitWords(base + 6, 400);
    for (int k = 0; k < 6; k++)
      check(logAddr[base+k] == 32'h2000 + 32'(4*(k%2)), "R7 address wraps to start",
            logAddr[base+k], 32'h2000 + 32'(4*(k%2)));
    regRead(2'd3, v);
    check(v[0] == 1 && v[3] == 1, "R7 still running, irq per pass", v, 32'hB);
    regWrite(2'd3, 32'h8);
    srcOn = 1'b0;
    regWrite(2'd3, 32'h4);
    for (int i = 0; i < 100; i++) begin
      regRead(2'd3, v);
      if (!v[2]) break;
    end
    regRead(2'd3, v);
    check(v[0] == 0 && v[2] == 0 && v[3] == 1, "R8 restart loop stopped", v, 32'h8);
    base = logCnt;
    repeat (20) @(negedge clk);
    check(logCnt == base && !memReq, "R8 no writes after stop", logCnt - base, 0);
    regWrite(2'd3, 32'h8);
  endtask

  task automatic testForcedDrain();
    logic [31:0] v;
    int base;
    int waited;
    ackOn = 1'b0;
    regWrite(2'd0, 32'h3000);
    regWrite(2'd1, 32'd64);
    srcOn = 1'b1;
    base = logCnt;
    regWrite(2'd3, 32'h1);
    repeat (12) @(negedge clk);
    srcOn = 1'b0;
    check(memReq && memAddr == 32'h3000, "R13 request held without ack", memAddr, 32'h3000);
    regWrite(2'd3, 32'h4);
    regRead(2'd3, v);
    check(v[2] == 1 && v[0] == 0, "R8 stop bit reads 1 while fifo holds data", v, 32'h4);
    check(sampleReady == 1'b0, "R8 intake closed", sampleReady, 0);
    regWrite(2'd0, 32'h5000);
    regWrite(2'd1, 32'd40);
    regWrite(2'd3, 32'h1);
    regRead(2'd3, v);
    check(v[2] == 1 && v[0] == 0, "R10 writes during drain do not run", v, 32'h4);
    ackOn = 1'b1;
    waited = 0;
    for (int i = 0; i < 100; i++) begin
      regRead(2'd3, v);
      if (!v[2]) break;
      waited++;
    end
    check(waited > 0, "R8 stop bit clears only after drain", waited, 1);
    check(logCnt - base == 4, "R8 fifo words drained", logCnt - base, 4);
    checkPass(base, 4, 32'h3000, "R8 drained order");
    regRead(2'd2, v);
    check(v == 48, "R9 residual count", v, 48);
    check(irq == 1'b1, "R8 irq on forced stop", irq, 1);
    base = logCnt;
    repeat (20) @(negedge clk);
    regRead(2'd3, v);
    check(v[0] == 0 && logCnt == base, "R10 idle after drain", v, 0);
    regRead(2'd0, v);
    check(v == 32'h5000, "R10 start write stored", v, 32'h5000);
    regWrite(2'd3, 32'h8);
  endtask

  task automatic testZeroCount();
    logic [31:0] v;
    int base;
    regWrite(2'd1, 32'd3);
    base = logCnt;
    regWrite(2'd3, 32'h1);
    check(irq == 1'b1, "R12 immediate irq", irq, 1);
    repeat (5) @(negedge clk);
    regRead(2'd3, v);
    check(v[0] == 0 && logCnt == base && !memReq, "R12 no transfer", v, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNormal();
    testRestart();
    testActWhileRunning();
    testAutoReload();
    testForcedDrain();
    testZeroCount();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule